// File: doc/BRIEF.md
# Paged MDIO-to-Register Bridge

This block sits on the slave side of a management link and lets a clause-22 MDIO master, which can only move 16 bits per transaction, read and write a space of 32-bit internal registers. It takes frames that are already decoded: a valid pulse, a read/write flag, the 5-bit PHY address, the 5-bit register number and the 16-bit write data. It drives a plain internal register bus with a word address, write data, a write strobe, a read strobe and read data that the register file returns in the same cycle.

The word address is too wide for one MDIO frame, so the bridge splits it into three parts. A page register, loaded through one fixed PHY/register pair, supplies the upper bits. The PHY address selects the middle bits. The register number selects the low bits. Each 32-bit register appears as an even/odd pair of MDIO registers. Writes go high half first: the odd write is held in a staging register. The even write then commits both halves in one bus cycle. Reads go low half first: the even read performs the bus read and keeps the upper half, so the odd read that follows returns the upper half of that same read.

Top module: `mdb_bridge`

## Requirements
- R1: The page register resets to 0. A write to PHY address 0x1F, register 0x10, loads the low 9 bits of the frame data into it. A read of that pair returns the page value, zero-extended to 16 bits.
- R2: For a frame to a data PHY address (0x10 to 0x17), the bus word address is {page[8:0], PHY address[2:0], register number[4:1]}. This gives 16 bits.
- R3: A write to an odd data register (register number bit 0 = 1) only stages its 16 bits. It produces no bus write strobe.
- R4: A write to an even data register produces exactly one bus write strobe. Its write data is {last staged high half, frame data}.
- R5: A read of an even data register produces exactly one bus read strobe. It returns bits [15:0] of the bus read data.
- R6: A read of an odd data register produces no bus read strobe. It returns bits [31:16] captured by the most recent even-register read, even if the register has changed since.
- R7: A frame to any other PHY/register combination has no effect: a write changes neither the page nor any bus strobe, and a read returns 0xFFFF.
- R8: Bus strobes are high for exactly the one cycle after the frame is sampled. A read response is valid for exactly one cycle, two cycles after the frame is sampled. Write frames produce no response.
- R9: After reset, no bus strobe and no response valid are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Decoded MDIO frame present for one cycle |
| frm_write | input | 1 | 1 = write frame, 0 = read frame |
| frm_phy | input | 5 | PHY address of the frame |
| frm_reg | input | 5 | Register number of the frame |
| frm_wdata | input | 16 | Write data of the frame |
| resp_valid | output | 1 | Read response valid |
| resp_data | output | 16 | Read response data |
| bus_addr | output | 16 | Internal word address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid during bus_rd |

## Verification
Bus strobes and the address appear one cycle after the frame's sampling edge. The bench drives each frame on a falling edge and looks at the strobes on the next falling edge. A monitor counts strobes at the rising edge that ends the strobe cycle. Read data comes back one edge later. The bench takes it on the second falling edge after the frame and requires the response-valid flag to be high exactly there. Random pages, addresses and data are mixed with directed cases. These include a register changed between the low and high reads, an orphan even write, unmapped addresses and page masking.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
   localparam int HALF_W = 16;
   localparam int MDIO_AW = 5;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_PAGE = 2'd1,
      K_LO   = 2'd2,
      K_HI   = 2'd3
   } kind_t;
endpackage

// File: rtl/mdb_decode.sv
module mdb_decode
   import mdb_pkg::*;
#(
   parameter int               SEL_W         = 3,
   parameter int               IDX_W         = 4,
   parameter logic [MDIO_AW-1:0] PAGE_PHY    = 5'h1F,
   parameter logic [MDIO_AW-1:0] PAGE_REG    = 5'h10,
   parameter logic [MDIO_AW-1:0] DATA_PHY_BASE = 5'h10
) (
   input  logic [MDIO_AW-1:0]     phy,
   input  logic [MDIO_AW-1:0]     regn,
   output kind_t                  kind,
   output logic [SEL_W+IDX_W-1:0] low_addr
);
   logic phy_hit;
   logic reg_hit;

   always_comb begin
      phy_hit  = (phy >> SEL_W) == (DATA_PHY_BASE >> SEL_W);
      reg_hit  = (regn >> (IDX_W + 1)) == '0;
      low_addr = {phy[SEL_W-1:0], regn[IDX_W:1]};
      if (phy == PAGE_PHY && regn == PAGE_REG)
         kind = K_PAGE;
      else if (phy_hit && reg_hit)
         kind = regn[0] ? K_HI : K_LO;
      else
         kind = K_NONE;
   end
endmodule

// File: rtl/mdb_hold_reg.sv
module mdb_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end
endmodule

// File: rtl/mdb_bridge.sv
module mdb_bridge
   import mdb_pkg::*;
#(
   parameter int               PAGE_W        = 9,
   parameter int               SEL_W         = 3,
   parameter int               IDX_W         = 4,
   parameter logic [4:0]       PAGE_PHY      = 5'h1F,
   parameter logic [4:0]       PAGE_REG      = 5'h10,
   parameter logic [4:0]       DATA_PHY_BASE = 5'h10,
   parameter bit               LATCH_HIGH    = 1'b1,
   localparam int              WADDR_W       = PAGE_W + SEL_W + IDX_W,
   localparam int              DATA_W        = 2 * HALF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_valid,
   input  logic               frm_write,
   input  logic [4:0]         frm_phy,
   input  logic [4:0]         frm_reg,
   input  logic [15:0]        frm_wdata,
   output logic               resp_valid,
   output logic [15:0]        resp_data,
   output logic [WADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic               bus_wr,
   output logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_rdata
);
   initial begin
      assert (PAGE_W >= 1 && PAGE_W <= HALF_W)
         else $fatal(1, "PAGE_W must fit one MDIO data word");
      assert (SEL_W >= 1 && SEL_W < MDIO_AW)
         else $fatal(1, "SEL_W must leave PHY bits for the base match");
      assert (IDX_W >= 1 && IDX_W + 1 <= MDIO_AW)
         else $fatal(1, "IDX_W plus the half bit must fit the register number");
      assert ((DATA_PHY_BASE & ((5'd1 << SEL_W) - 5'd1)) == 5'd0)
         else $fatal(1, "DATA_PHY_BASE low bits must be zero");
   end

   kind_t                    dk;
   logic [SEL_W+IDX_W-1:0]   dlow;
   logic [PAGE_W-1:0]        page_q;
   logic [HALF_W-1:0]        stage_hi;
   logic [HALF_W-1:0]        hi_src;
   logic                     is_wr;
   logic                     is_rd;
   logic                     rd_issue;
   logic                     s1_rvalid;
   kind_t                    s1_kind;
   logic [PAGE_W-1:0]        s1_page;

   mdb_decode #(
      .SEL_W(SEL_W), .IDX_W(IDX_W), .PAGE_PHY(PAGE_PHY),
      .PAGE_REG(PAGE_REG), .DATA_PHY_BASE(DATA_PHY_BASE)
   ) u_dec (
      .phy(frm_phy), .regn(frm_reg), .kind(dk), .low_addr(dlow)
   );

   assign is_wr = frm_valid && frm_write;
   assign is_rd = frm_valid && !frm_write;

   mdb_hold_reg #(.W(PAGE_W)) u_page (
      .clk(clk), .rst_n(rst_n),
      .load(is_wr && dk == K_PAGE),
      .din(frm_wdata[PAGE_W-1:0]),
      .q(page_q)
   );

   mdb_hold_reg #(.W(HALF_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .load(is_wr && dk == K_HI),
      .din(frm_wdata),
      .q(stage_hi)
   );

   generate
      if (LATCH_HIGH) begin : g_latch
         mdb_hold_reg #(.W(HALF_W)) u_lat (
            .clk(clk), .rst_n(rst_n),
            .load(s1_rvalid && s1_kind == K_LO),
            .din(bus_rdata[DATA_W-1:HALF_W]),
            .q(hi_src)
         );
         assign rd_issue = is_rd && dk == K_LO;
      end else begin : g_reread
         assign hi_src   = bus_rdata[DATA_W-1:HALF_W];
         assign rd_issue = is_rd && (dk == K_LO || dk == K_HI);
      end
   endgenerate

   // stage 1: bus strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_wr    <= 1'b0;
         bus_rd    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         s1_rvalid <= 1'b0;
         s1_kind   <= K_NONE;
         s1_page   <= '0;
      end else begin
         bus_wr    <= is_wr && dk == K_LO;
         bus_rd    <= rd_issue;
         s1_rvalid <= is_rd;
         s1_kind   <= dk;
         s1_page   <= page_q;
         if (frm_valid && (dk == K_LO || dk == K_HI))
            bus_addr <= {page_q, dlow};
         if (is_wr && dk == K_LO)
            bus_wdata <= {stage_hi, frm_wdata};
      end
   end

   // stage 2: read response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_data  <= '0;
      end else begin
         resp_valid <= s1_rvalid;
         if (s1_rvalid) begin
            unique case (s1_kind)
               K_PAGE:  resp_data <= HALF_W'(s1_page);
               K_LO:    resp_data <= bus_rdata[HALF_W-1:0];
               K_HI:    resp_data <= hi_src;
               default: resp_data <= '1;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdb_bridge_chk.sv
module mdb_bridge_chk #(
   parameter int         SEL_W         = 3,
   parameter int         IDX_W         = 4,
   parameter int         PAGE_W        = 9,
   parameter int         WADDR_W       = 16,
   parameter logic [4:0] PAGE_PHY      = 5'h1F,
   parameter logic [4:0] PAGE_REG      = 5'h10,
   parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frm_valid,
   input logic               frm_write,
   input logic [4:0]         frm_phy,
   input logic [4:0]         frm_reg,
   input logic               resp_valid,
   input logic [15:0]        resp_data,
   input logic [WADDR_W-1:0] bus_addr,
   input logic               bus_wr,
   input logic               bus_rd
);
   logic at_data;
   logic at_page;
   assign at_data = ((frm_phy >> SEL_W) == (DATA_PHY_BASE >> SEL_W));
   assign at_page = (frm_phy == PAGE_PHY) && (frm_reg == PAGE_REG);

   // R9 / R4: never both strobes
   a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   a_r3_hi_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_write && at_data && frm_reg[0] |=> !bus_wr);

   a_r4_lo_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_write && at_data && !frm_reg[0] |=> bus_wr);

   a_r2_word_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && at_data && !frm_reg[0] |=>
      bus_addr[SEL_W+IDX_W-1:0] == {$past(frm_phy[SEL_W-1:0]), $past(frm_reg[IDX_W:1])});

   a_r5_lo_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_write && at_data && !frm_reg[0] |=> bus_rd);

   a_r8_read_resp_due: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_write |=> ##1 resp_valid);

   a_r8_write_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_write |=> ##1 !resp_valid);

   a_r7_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_write && !at_data && !at_page |=> ##1 resp_data == 16'hFFFF);

   a_r1_page_width: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_write && at_page |=> ##1 (resp_data >> PAGE_W) == 16'h0);
endmodule

bind mdb_bridge mdb_bridge_chk #(
   .SEL_W(SEL_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .WADDR_W(WADDR_W),
   .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG), .DATA_PHY_BASE(DATA_PHY_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_write(frm_write),
   .frm_phy(frm_phy), .frm_reg(frm_reg), .resp_valid(resp_valid),
   .resp_data(resp_data), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd)
);

// File: tb/mdb_bridge_test.sv
module mdb_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic        frm_write = 1'b0;
   logic [4:0]  frm_phy = '0;
   logic [4:0]  frm_reg = '0;
   logic [15:0] frm_wdata = '0;
   logic        resp_valid;
   logic [15:0] resp_data;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_wr;
   logic        bus_rd;
   logic [31:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   logic [15:0] last_waddr = '0;
   logic [31:0] last_wdata = '0;
   logic [31:0] mem [32];
   logic        resp_seen;
   logic [15:0] resp_got;

   always #2 clk = ~clk;

   mdb_bridge uut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_write(frm_write),
      .frm_phy(frm_phy), .frm_reg(frm_reg), .frm_wdata(frm_wdata),
      .resp_valid(resp_valid), .resp_data(resp_data), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   assign bus_rdata = mem[bus_addr[4:0]];

   always @(posedge clk) begin
      if (bus_wr) begin
         wr_cnt++;
         last_waddr = bus_addr;
         last_wdata = bus_wdata;
         mem[bus_addr[4:0]] = bus_wdata;
      end
      if (bus_rd) rd_cnt++;
   end

   function automatic logic [15:0] exp_addr(logic [8:0] pg, logic [2:0] sel, logic [3:0] idx);
      return {pg, sel, idx};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one frame; resp_seen/resp_got sampled two falling edges later
   task automatic frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
      @(negedge clk);
      frm_valid = 1'b1; frm_write = wr; frm_phy = phy; frm_reg = rg; frm_wdata = d;
      @(negedge clk);
      frm_valid = 1'b0;
      if (resp_valid) check(0, "R8 early response", 32'(resp_valid), 0);
      @(negedge clk);
      resp_seen = resp_valid;
      resp_got  = resp_data;
      check(resp_seen == !wr, "R8 response timing", 32'(resp_seen), 32'(!wr));
      @(negedge clk);
      if (resp_valid) check(0, "R8 response longer than one cycle", 32'(resp_valid), 0);
   endtask

   task automatic set_page(input logic [8:0] pg);
      frame(1'b1, 5'h1F, 5'h10, {7'h55, pg});
   endtask

   task automatic wr32(input logic [2:0] sel, input logic [3:0] idx, input logic [31:0] d);
      frame(1'b1, {2'b10, sel}, {idx, 1'b1}, d[31:16]);
      frame(1'b1, {2'b10, sel}, {idx, 1'b0}, d[15:0]);
   endtask

   initial begin
      #(4ns * 200000);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int wc, rc;
      logic [15:0] lo, hi;
      void'($urandom(32'h0000_5EED));
      for (int i = 0; i < 32; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(!bus_wr && !bus_rd && !resp_valid, "R9 outputs idle in reset",
            {29'b0, bus_wr, bus_rd, resp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!bus_wr && !bus_rd && !resp_valid, "R9 outputs idle after reset",
            {29'b0, bus_wr, bus_rd, resp_valid}, 0);

      // R1 page reset value and masking
      frame(1'b0, 5'h1F, 5'h10, 0);
      check(resp_got == 16'h0, "R1 page resets to zero", resp_got, 0);
      frame(1'b1, 5'h1F, 5'h10, 16'hFFFF);
      frame(1'b0, 5'h1F, 5'h10, 0);
      check(resp_got == 16'h01FF, "R1 page keeps 9 bits", resp_got, 16'h01FF);

      // R3 high write stages only; R4 low write commits
      set_page(9'h0A5);
      wc = wr_cnt;
      frame(1'b1, 5'h13, 5'h07, 16'hCAFE);
      check(wr_cnt == wc, "R3 odd write makes no strobe", wr_cnt - wc, 0);
      frame(1'b1, 5'h13, 5'h06, 16'hBEEF);
      check(wr_cnt == wc + 1, "R4 even write one strobe", wr_cnt - wc, 1);
      check(last_wdata == 32'hCAFE_BEEF, "R4 write data", last_wdata, 32'hCAFE_BEEF);
      check(last_waddr == exp_addr(9'h0A5, 3'd3, 4'd3), "R2 write address",
            last_waddr, exp_addr(9'h0A5, 3'd3, 4'd3));

      // R4 orphan even write reuses last staged high
      frame(1'b1, 5'h13, 5'h06, 16'h1234);
      check(last_wdata == 32'hCAFE_1234, "R4 reuse staged high", last_wdata, 32'hCAFE_1234);

      // R5/R6 read pair with register changed in between
      rc = rd_cnt;
      frame(1'b0, 5'h13, 5'h06, 0);
      check(resp_got == 16'h1234, "R5 low half read", resp_got, 16'h1234);
      check(rd_cnt == rc + 1, "R5 one read strobe", rd_cnt - rc, 1);
      mem[exp_addr(9'h0A5, 3'd3, 4'd3) & 16'h1F] = 32'h9999_8888;
      frame(1'b0, 5'h13, 5'h07, 0);
      check(resp_got == 16'hCAFE, "R6 high half from latched read", resp_got, 16'hCAFE);
      check(rd_cnt == rc + 1, "R6 odd read makes no strobe", rd_cnt - rc, 1);

      // R7 unmapped addresses
      wc = wr_cnt; rc = rd_cnt;
      frame(1'b1, 5'h05, 5'h02, 16'h7777);
      frame(1'b1, 5'h1F, 5'h11, 16'h0003);
      frame(1'b0, 5'h08, 5'h00, 0);
      check(resp_got == 16'hFFFF, "R7 unmapped read ones", resp_got, 16'hFFFF);
      frame(1'b0, 5'h1F, 5'h02, 0);
      check(resp_got == 16'hFFFF, "R7 page phy other reg reads ones", resp_got, 16'hFFFF);
      check(wr_cnt == wc && rd_cnt == rc, "R7 no strobes", wr_cnt - wc + rd_cnt - rc, 0);
      frame(1'b0, 5'h1F, 5'h10, 0);
      check(resp_got == 16'h00A5, "R7 page untouched", resp_got, 16'h00A5);

      // random round trips
      for (int n = 0; n < 40; n++) begin
         logic [8:0]  pg;
         logic [2:0]  sel;
         logic [3:0]  idx;
         logic [31:0] d;
         pg = 9'($urandom); sel = 3'($urandom); idx = 4'($urandom); d = $urandom;
         set_page(pg);
         wr32(sel, idx, d);
         check(last_waddr == exp_addr(pg, sel, idx), "R2 random address",
               last_waddr, exp_addr(pg, sel, idx));
         check(last_wdata == d, "R4 random data", last_wdata, d);
         frame(1'b0, {2'b10, sel}, {idx, 1'b0}, 0);
         lo = resp_got;
         frame(1'b0, {2'b10, sel}, {idx, 1'b1}, 0);
         hi = resp_got;
         check({hi, lo} == d, "R5 R6 random readback", {hi, lo}, d);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule